// File: doc/BRIEF.md
# 8051 Internal Data RAM Decoder

This block holds the 256 bytes of on-core data memory for an 8051-style processor and decides, for every access, which store it reaches. The lower half of the address space is one 128-byte RAM that any addressing mode can reach. The upper half has two physically distinct targets: a second 128-byte RAM, reached only by indirect accesses, and the special function register (SFR) space, reached by direct accesses. The SFR contents are outside this block. For an SFR access it raises a select strobe with the SFR address and leaves both RAM arrays untouched.

Two other ways of forming an address feed the same decoder. The first is a register operand: an index from 0 to 7 combined with a two-bit bank select. The second is a bit address. Bit addresses below 0x80 point into a 16-byte window of the lower RAM. Bit addresses from 0x80 upward point at the bit-addressable SFRs. A bit write is performed as a read-modify-write of the containing byte in a single cycle. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `idata_ram_router`

## Requirements
- R1: A byte access to an address from 0x00 to 0x7F reaches the same lower-RAM byte whether `indirect` is 0 (direct) or 1 (indirect). A value written in one mode reads back in the other.
- R2: When `reg_mode` is 1, it overrides `bit_mode` and `addr`. The access targets lower-RAM byte `bank_sel*8 + reg_num`, and `sfr_sel` stays 0.
- R3: When `bit_mode` is 1 and `bit_addr` is below 0x80, the access targets lower-RAM byte 0x20 + (`bit_addr` / 8). `bit_rdata` equals bit (`bit_addr` mod 8) of that byte, and `rdata` shows the whole byte.
- R4: A bit write (`wr_en`=1, `bit_mode`=1, `bit_addr` below 0x80) sets the selected bit to `bit_wdata` and leaves the other seven bits of that byte unchanged.
- R5: A direct byte access (`indirect`=0) to an address from 0x80 to 0xFF raises `sfr_sel`, drives `sfr_addr` equal to `addr` and drives `rdata` to 0. Neither RAM is written.
- R6: An indirect byte access to an address from 0x80 to 0xFF reaches a separate 128-byte upper RAM and keeps `sfr_sel` at 0. The upper RAM is never changed by direct accesses to the same addresses.
- R7: A bit access with `bit_addr` from 0x80 to 0xFF raises `sfr_sel`, drives `sfr_addr` to `bit_addr` with its three low bits cleared, and drives `rdata` and `bit_rdata` to 0. No RAM byte changes.
- R8: After reset every byte of both RAMs reads 0. Reads follow the inputs combinationally. A write becomes visible at the rising clock edge on which `wr_en` is 1. When `sfr_sel` is 0, `sfr_addr` is 0. `bit_rdata` is 0 for byte accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both RAMs |
| addr | input | 8 | Byte address for plain byte accesses |
| indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| bit_mode | input | 1 | 1 = bit access using `bit_addr` |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Value written by a bit write |
| reg_mode | input | 1 | 1 = register-operand access (highest priority) |
| reg_num | input | 3 | Register index 0 to 7 |
| bank_sel | input | 2 | Active register bank |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Byte write data |
| rdata | output | 8 | Byte read data, 0 when the access goes to SFR space |
| bit_rdata | output | 1 | Selected bit for bit accesses into RAM |
| sfr_sel | output | 1 | Access is routed to SFR space |
| sfr_addr | output | 8 | SFR byte address, 0 when `sfr_sel` is 0 |

## Verification
The stimulus mixes byte accesses in both modes across the whole address range, register-operand accesses in every bank, and bit accesses on both sides of 0x80. Each is checked against a bench model that keeps separate lower and upper arrays. Direct and indirect traffic to the same high address shows whether the two upper stores stay distinct. Writes made through the register path or the bit path and then read back as plain bytes show whether the bank and bit arithmetic point at the right byte. Repeated bit writes into one byte show whether neighbouring bits survive the read-modify-write.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int IDR_AW     = 8;
  localparam int IDR_DW     = 8;
  localparam int IDR_REG_W  = 3;
  localparam int IDR_BANK_W = 2;
  localparam int IDR_BIDX_W = $clog2(IDR_DW);
  localparam int IDR_HALF   = 1 << (IDR_AW - 1);
  localparam logic [IDR_AW-1:0] IDR_BIT_BASE = 8'h20;

  typedef enum logic [1:0] {
    RT_LOWER = 2'd0,
    RT_UPPER = 2'd1,
    RT_SFR   = 2'd2
  } route_e;

  // register operand -> byte address: bank*8 + n
  function automatic logic [IDR_AW-1:0] reg_slot_addr(
      input logic [IDR_BANK_W-1:0] bank, input logic [IDR_REG_W-1:0] n);
    logic [IDR_AW-1:0] r;
    r = '0;
    r[IDR_REG_W +: IDR_BANK_W] = bank;
    r[IDR_REG_W-1:0] = n;
    return r;
  endfunction

  // RAM bit address -> containing byte
  function automatic logic [IDR_AW-1:0] bit_home_byte(input logic [IDR_AW-1:0] b);
    return IDR_BIT_BASE + IDR_AW'(b[IDR_AW-2:IDR_BIDX_W]);
  endfunction

  // SFR bit address -> byte on an 8-aligned boundary
  function automatic logic [IDR_AW-1:0] sfr_bit_byte(input logic [IDR_AW-1:0] b);
    logic [IDR_AW-1:0] r;
    r = b;
    r[IDR_BIDX_W-1:0] = '0;
    return r;
  endfunction

  function automatic logic [IDR_DW-1:0] put_bit(
      input logic [IDR_DW-1:0] byte_in, input logic [IDR_BIDX_W-1:0] idx, input logic v);
    logic [IDR_DW-1:0] r;
    r = byte_in;
    r[idx] = v;
    return r;
  endfunction
endpackage

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
(
  input  logic [IDR_AW-1:0]     addr,
  input  logic                  indirect,
  input  logic                  bit_mode,
  input  logic [IDR_AW-1:0]     bit_addr,
  input  logic                  reg_mode,
  input  logic [IDR_REG_W-1:0]  reg_num,
  input  logic [IDR_BANK_W-1:0] bank_sel,
  output logic [IDR_AW-1:0]     eff_addr,
  output route_e                route,
  output logic [IDR_BIDX_W-1:0] bit_idx,
  output logic                  bit_in_ram
);
  logic bit_is_sfr;
  assign bit_is_sfr = bit_addr[IDR_AW-1];
  assign bit_idx    = bit_addr[IDR_BIDX_W-1:0];

  always_comb begin
    eff_addr   = addr;
    route      = RT_LOWER;
    bit_in_ram = 1'b0;
    if (reg_mode) begin
      eff_addr = reg_slot_addr(bank_sel, reg_num);
      route    = RT_LOWER;
    end else if (bit_mode) begin
      if (bit_is_sfr) begin
        eff_addr = sfr_bit_byte(bit_addr);
        route    = RT_SFR;
      end else begin
        eff_addr   = bit_home_byte(bit_addr);
        route      = RT_LOWER;
        bit_in_ram = 1'b1;
      end
    end else if (addr[IDR_AW-1]) begin
      route = indirect ? RT_UPPER : RT_SFR;
    end
  end
endmodule

// File: rtl/idr_store.sv
module idr_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wbyte,
  output logic [DATA_W-1:0] rbyte
);
  logic [DATA_W-1:0] cells [DEPTH];

  assign rbyte = cells[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wbyte;
    end
  end
endmodule

// File: rtl/idr_bit_merge.sv
module idr_bit_merge
  import idr_pkg::*;
(
  input  logic [IDR_DW-1:0]     old_byte,
  input  logic [IDR_DW-1:0]     wdata,
  input  logic                  bit_in_ram,
  input  logic [IDR_BIDX_W-1:0] bit_idx,
  input  logic                  bit_wdata,
  output logic [IDR_DW-1:0]     new_byte,
  output logic                  bit_out
);
  assign new_byte = bit_in_ram ? put_bit(old_byte, bit_idx, bit_wdata) : wdata;
  assign bit_out  = bit_in_ram & old_byte[bit_idx];
endmodule

// File: rtl/idata_ram_router.sv
module idata_ram_router
  import idr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDR_AW-1:0]     addr,
  input  logic                  indirect,
  input  logic                  bit_mode,
  input  logic [IDR_AW-1:0]     bit_addr,
  input  logic                  bit_wdata,
  input  logic                  reg_mode,
  input  logic [IDR_REG_W-1:0]  reg_num,
  input  logic [IDR_BANK_W-1:0] bank_sel,
  input  logic                  wr_en,
  input  logic [IDR_DW-1:0]     wdata,
  output logic [IDR_DW-1:0]     rdata,
  output logic                  bit_rdata,
  output logic                  sfr_sel,
  output logic [IDR_AW-1:0]     sfr_addr
);
  localparam int NSTORE = 2;
  localparam int IW     = $clog2(IDR_HALF);

  logic [IDR_AW-1:0]     eff_addr;
  route_e                route;
  logic [IDR_BIDX_W-1:0] bit_idx;
  logic                  bit_in_ram;
  logic [IDR_DW-1:0]     store_q [NSTORE];
  logic [NSTORE-1:0]     store_we;
  logic [IDR_DW-1:0]     cur_byte;
  logic [IDR_DW-1:0]     new_byte;
  logic                  bit_out;

  idr_decode u_dec (
    .addr(addr), .indirect(indirect), .bit_mode(bit_mode), .bit_addr(bit_addr),
    .reg_mode(reg_mode), .reg_num(reg_num), .bank_sel(bank_sel),
    .eff_addr(eff_addr), .route(route), .bit_idx(bit_idx), .bit_in_ram(bit_in_ram)
  );

  // store 0 = lower RAM, store 1 = indirect-only upper RAM
  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam route_e MY_RT = (g == 0) ? RT_LOWER : RT_UPPER;
    assign store_we[g] = wr_en && (route == MY_RT);
    idr_store #(.DEPTH(IDR_HALF), .DATA_W(IDR_DW)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(store_we[g]),
      .idx(eff_addr[IW-1:0]), .wbyte(new_byte), .rbyte(store_q[g])
    );
  end

  always_comb begin
    case (route)
      RT_LOWER: cur_byte = store_q[0];
      RT_UPPER: cur_byte = store_q[1];
      default:  cur_byte = '0;
    endcase
  end

  idr_bit_merge u_merge (
    .old_byte(cur_byte), .wdata(wdata), .bit_in_ram(bit_in_ram),
    .bit_idx(bit_idx), .bit_wdata(bit_wdata), .new_byte(new_byte), .bit_out(bit_out)
  );

  assign rdata     = cur_byte;
  assign bit_rdata = bit_out;
  assign sfr_sel   = (route == RT_SFR);
  assign sfr_addr  = sfr_sel ? eff_addr : '0;
endmodule

// File: rtl/idr_checker.sv
module idr_checker
  import idr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [IDR_AW-1:0]     addr,
  input logic                  indirect,
  input logic                  bit_mode,
  input logic [IDR_AW-1:0]     bit_addr,
  input logic                  bit_wdata,
  input logic                  reg_mode,
  input logic                  wr_en,
  input logic [IDR_DW-1:0]     wdata,
  input logic [IDR_DW-1:0]     rdata,
  input logic                  bit_rdata,
  input logic                  sfr_sel,
  input logic [IDR_AW-1:0]     sfr_addr,
  input logic [1:0]            store_we
);
  logic byte_acc;
  assign byte_acc = !reg_mode && !bit_mode;

  assert_reg_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_mode |-> (!sfr_sel && !store_we[1]));

  assert_bit_write_keeps_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bit_mode && !reg_mode && !bit_addr[IDR_AW-1]) |=>
      ((bit_mode && !reg_mode && $stable(bit_addr)) ->
        ((((rdata ^ $past(rdata)) & ~(8'h01 << bit_addr[2:0])) == 8'h00) &&
         (bit_rdata == $past(bit_wdata)))));

  assert_direct_high_sfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !indirect && addr[IDR_AW-1]) |-> (sfr_sel && sfr_addr == addr && rdata == 8'h00));

  assert_sfr_no_ram_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (store_we == 2'b00));

  assert_indirect_high_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && indirect && addr[IDR_AW-1]) |-> !sfr_sel);

  assert_sfr_bit_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_mode && !reg_mode && bit_addr[IDR_AW-1]) |->
      (sfr_sel && sfr_addr == {bit_addr[7:3], 3'b000} && !bit_rdata));

  assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_acc && !sfr_sel) |=>
      ((byte_acc && $stable(addr) && $stable(indirect)) -> (rdata == $past(wdata))));

  assert_sfr_addr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_sel |-> (sfr_addr == 8'h00));
endmodule

bind idata_ram_router idr_checker u_idr_checker (
  .clk(clk), .rst_n(rst_n), .addr(addr), .indirect(indirect), .bit_mode(bit_mode),
  .bit_addr(bit_addr), .bit_wdata(bit_wdata), .reg_mode(reg_mode), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .bit_rdata(bit_rdata), .sfr_sel(sfr_sel),
  .sfr_addr(sfr_addr), .store_we(store_we)
);

// File: tb/idata_ram_router_bench.sv
module idata_ram_router_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       indirect = 1'b0;
  logic       bit_mode = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_wdata = 1'b0;
  logic       reg_mode = 1'b0;
  logic [2:0] reg_num = '0;
  logic [1:0] bank_sel = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bit_rdata;
  logic       sfr_sel;
  logic [7:0] sfr_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [128];
  logic [7:0] m_up [128];

  always #2 clk = ~clk;

  idata_ram_router u_idata_ram_router (
    .clk(clk), .rst_n(rst_n), .addr(addr), .indirect(indirect), .bit_mode(bit_mode),
    .bit_addr(bit_addr), .bit_wdata(bit_wdata), .reg_mode(reg_mode), .reg_num(reg_num),
    .bank_sel(bank_sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .bit_rdata(bit_rdata), .sfr_sel(sfr_sel), .sfr_addr(sfr_addr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target: 0 lower, 1 upper, 2 sfr; returns byte address
  function automatic int ref_target(input logic rm, bm, ind, input int a, ba, bk, rn,
                                    output int tgt, output string req);
    if (rm) begin tgt = 0; req = "R2"; return bk * 8 + rn; end
    if (bm) begin
      if (ba < 128) begin tgt = 0; req = "R3"; return 32 + ba / 8; end
      tgt = 2; req = "R7"; return (ba / 8) * 8;
    end
    if (a < 128) begin tgt = 0; req = "R1"; return a; end
    if (ind) begin tgt = 1; req = "R6"; return a; end
    tgt = 2; req = "R5"; return a;
  endfunction

  task automatic op(input string tag, input logic [7:0] a, input logic ind, bm,
                    input logic [7:0] ba, input logic bv, we, input logic [7:0] wd,
                    input logic [1:0] bk, input logic rm, input logic [2:0] rn);
    int tgt; int ea; int k; string req;
    logic [7:0] cur; logic [7:0] nb;
    @(negedge clk);
    addr = a; indirect = ind; bit_mode = bm; bit_addr = ba; bit_wdata = bv;
    wr_en = we; wdata = wd; bank_sel = bk; reg_mode = rm; reg_num = rn;
    #1;
    ea  = ref_target(rm, bm, ind, int'(a), int'(ba), int'(bk), int'(rn), tgt, req);
    if (tag != "") req = tag;
    k   = int'(ba) % 8;
    cur = (tgt == 0) ? m_lo[ea] : (tgt == 1) ? m_up[ea - 128] : 8'h00;
    check(req, "rdata", int'(rdata), int'(cur));
    check(req, "bit_rdata", int'(bit_rdata), (bm && !rm && tgt == 0) ? int'(cur[k]) : 0);
    check(req, "sfr_sel", int'(sfr_sel), (tgt == 2) ? 1 : 0);
    check(req, "sfr_addr", int'(sfr_addr), (tgt == 2) ? ea : 0);
    if (we && tgt != 2) begin
      if (bm && !rm) nb = (cur & ~(8'h01 << k)) | (8'(bv) << k);
      else nb = wd;
      if (tgt == 0) m_lo[ea] = nb; else m_up[ea - 128] = nb;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; reg_mode = 1'b0; bit_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_lo[i] = 8'h00; m_up[i] = 8'h00; end
    void'($urandom(32'h0000_51A7));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: reset state in both RAMs
    op("R8", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R8", 8'h7F, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R8", 8'hC3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // R1: direct write, indirect read back
    op("R1", 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3C, 2'd0, 1'b0, 3'd0);
    op("R1", 8'h40, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // R2: bank 3, R5 -> byte 0x1D
    op("R2", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hD7, 2'd3, 1'b1, 3'd5);
    op("R2", 8'h1D, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // R3 / R4: byte 0x2F preset, then bit 0x7F cleared, others kept
    op("R4", 8'h2F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 2'd0, 1'b0, 3'd0);
    op("R4", 8'h00, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R4", 8'h2F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R3", 8'h00, 1'b0, 1'b1, 8'h03, 1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R3", 8'h20, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // R5 / R6: the two stores behind 0x90 stay apart
    op("R5", 8'h90, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 2'd0, 1'b0, 3'd0);
    op("R6", 8'h90, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R6", 8'h90, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h5A, 2'd0, 1'b0, 3'd0);
    op("R5", 8'h90, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R6", 8'h90, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R5", 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // R7: SFR bit write touches no RAM
    op("R7", 8'h00, 1'b0, 1'b1, 8'hE3, 1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 3'd0);
    op("R7", 8'h60, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    // random mix over all paths
    for (int n = 0; n < 3000; n++) begin
      logic rm, bm;
      rm = ($urandom % 5) == 0;
      bm = ($urandom % 4) == 0;
      op("", 8'($urandom), 1'($urandom), bm, 8'($urandom), 1'($urandom),
         1'($urandom), 8'($urandom), 2'($urandom), rm, 3'($urandom));
    end

    // sweep: every lower and upper byte against the model
    for (int a = 0; a < 256; a++)
      op("R8", 8'(a), 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 3'd0);

    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule